// File: doc/BRIEF.md
# UART Flow-Control Gate and Transceiver Enable

This block sits between a UART's transmit holding stage and its bit shifter. It decides when a new character may begin, based on the remote side's clear-to-send line (nCTS, active low). It also drives one output pin that serves either as the local request-to-send line (nRTS, active low) or as a driver-enable signal for an external half-duplex transceiver. A character that is already on the wire always runs to its end. Flow control only holds back the next character.

The nCTS input is asynchronous and passes through a flop synchronizer. Any edge on the synchronized level, while CTS flow control is on, sets a sticky change flag. That flag can raise an interrupt. The four pin and gating configuration bits are captured only while the UART is disabled, so changing them during operation has no effect. The shifter itself is outside the block. It reports busy for the length of a frame and pulses a done signal in the last cycle of the final stop bit.

Top module: `uart_flow_gate`

## Requirements
- R1: With CTS gating configured on, `tx_start_o` is asserted only while the synchronized nCTS level is 0.
- R2: If nCTS rises while a character is in flight, that character completes. The next pending character does not start until nCTS is low again.
- R3: A character requested while nCTS is high starts as soon as nCTS goes low. When nCTS falls just after clock edge k, `tx_start_o` is high after edge k+2 (two-flop synchronizer).
- R4: In RTS mode (driver-enable mode off, RTS on), `rts_de_o` is 0 one clock after the UART is enabled and the receive buffer has space. Otherwise it is 1.
- R5: In driver-enable mode with polarity 0, `rts_de_o` is 1 from the clock edge that accepts a start until the clock edge that ends the cycle where done is high. This is exactly the cycles the shifter reports busy. It is 0 when idle.
- R6: In driver-enable mode with polarity 1, `rts_de_o` is the inverse of the R5 waveform, so it idles at 1.
- R7: The cts_en, rts_en, de_mode and de_pol inputs are captured only on clock edges where `uart_en_i` is 0. While the UART is enabled, changing them has no effect.
- R8: With CTS gating on, each change of the synchronized nCTS sets `cts_flag_o` three clocks after the input edge. The flag stays set until `cts_clr_i`. `cts_irq_o` equals the flag ANDed with `cts_irq_en_i`.
- R9: With CTS gating off, nCTS is ignored: starts are not held and the flag is not set. With RTS and driver-enable both off, `rts_de_o` is 0.
- R10: After reset, `tx_start_o`, `rts_de_o`, `cts_flag_o` and `cts_irq_o` are all 0.
- R11: No start is granted while the shifter is busy or while `uart_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uart_en_i | input | 1 | UART enable; configuration is captured while 0 |
| cts_en_i | input | 1 | CTS gating enable |
| rts_en_i | input | 1 | RTS output enable |
| de_mode_i | input | 1 | Pin carries driver-enable instead of nRTS |
| de_pol_i | input | 1 | Driver-enable polarity: 0 active high, 1 active low |
| cts_irq_en_i | input | 1 | CTS change interrupt enable |
| cts_n_i | input | 1 | Remote clear-to-send, active low, asynchronous |
| tx_valid_i | input | 1 | A character is waiting to be sent |
| tx_busy_i | input | 1 | Shifter is sending a frame |
| tx_done_i | input | 1 | Last cycle of the final stop bit |
| rx_space_i | input | 1 | Receive buffer can take a character |
| cts_clr_i | input | 1 | Clears the CTS change flag |
| tx_start_o | output | 1 | Grant: shifter loads and starts a frame |
| rts_de_o | output | 1 | Shared nRTS / driver-enable pin, registered |
| cts_flag_o | output | 1 | Sticky CTS change flag |
| cts_irq_o | output | 1 | CTS change interrupt |

## Verification
The hardest case to reach is nCTS rising in the middle of a frame while a second character is already queued. It must be shown that the frame in flight is not cut short and that the queued one waits. The bench gets there by queueing two characters with nCTS low. It lets the first one be granted, raises nCTS on the very next falling edge, and holds it high through the done pulse and several idle cycles. It then lowers nCTS and counts the sync delay to the second grant.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  typedef struct packed {
    logic cts_en;
    logic rts_en;
    logic de_mode;
    logic de_pol;
  } fc_cfg_t;

  localparam fc_cfg_t FC_CFG_RST = '0;
endpackage

// File: rtl/fc_cfg_shadow.sv
module fc_cfg_shadow
  import uart_fc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    uart_en_i,
  input  fc_cfg_t cfg_i,
  output fc_cfg_t cfg_o
);
  fc_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cfg_q <= FC_CFG_RST;
    else if (!uart_en_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;

  p_cfg_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uart_en_i |=> $stable(cfg_o));
endmodule

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_n_i,
  input  logic watch_i,
  input  logic clr_i,
  output logic cts_n_s_o,
  output logic flag_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              flag_q;
  logic              chg;

  // idle value is deasserted (high) so reset never looks like an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], cts_n_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign chg       = sync_q[STAGES-1] ^ prev_q;
  assign cts_n_s_o = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flag_q <= 1'b0;
    else if (chg && watch_i)   flag_q <= 1'b1;
    else if (clr_i)            flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_chg_sets_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && watch_i) |=> flag_o);
  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/fc_frame_track.sv
module fc_frame_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  output logic active_o,
  output logic active_d_o
);
  logic active_q;
  logic active_d;

  always_comb begin
    active_d = active_q;
    if (start_i)     active_d = 1'b1;
    else if (done_i) active_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_d;
  end

  assign active_o   = active_q;
  assign active_d_o = active_d;

  p_de_on_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_o);
  p_de_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !done_i) |=> active_o);
  p_de_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i) |=> !active_o);
endmodule

// File: rtl/uart_flow_gate.sv
module uart_flow_gate
  import uart_fc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uart_en_i,
  input  logic cts_en_i,
  input  logic rts_en_i,
  input  logic de_mode_i,
  input  logic de_pol_i,
  input  logic cts_irq_en_i,
  input  logic cts_n_i,
  input  logic tx_valid_i,
  input  logic tx_busy_i,
  input  logic tx_done_i,
  input  logic rx_space_i,
  input  logic cts_clr_i,
  output logic tx_start_o,
  output logic rts_de_o,
  output logic cts_flag_o,
  output logic cts_irq_o
);
  fc_cfg_t cfg_in, cfg;
  logic    cts_n_s;
  logic    de_act, de_act_d;
  logic    pin_d, pin_q;
  logic    cts_ok;

  assign cfg_in = '{cts_en: cts_en_i, rts_en: rts_en_i,
                    de_mode: de_mode_i, de_pol: de_pol_i};

  fc_cfg_shadow u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .uart_en_i(uart_en_i),
    .cfg_i    (cfg_in),
    .cfg_o    (cfg)
  );

  fc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cts_n_i  (cts_n_i),
    .watch_i  (cfg.cts_en),
    .clr_i    (cts_clr_i),
    .cts_n_s_o(cts_n_s),
    .flag_o   (cts_flag_o)
  );

  // gate only new starts; a frame in flight is governed by busy alone
  assign cts_ok     = !cfg.cts_en || !cts_n_s;
  assign tx_start_o = uart_en_i && tx_valid_i && !tx_busy_i && cts_ok;

  fc_frame_track u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (tx_start_o),
    .done_i    (tx_done_i),
    .active_o  (de_act),
    .active_d_o(de_act_d)
  );

  always_comb begin
    if (cfg.de_mode)     pin_d = de_act_d ^ cfg.de_pol;
    else if (cfg.rts_en) pin_d = !(uart_en_i && rx_space_i);
    else                 pin_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_d;
  end

  assign rts_de_o  = pin_q;
  assign cts_irq_o = cts_flag_o && cts_irq_en_i;

  p_start_cts_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_o && cfg.cts_en) |-> !cts_n_s);
  p_start_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> (!tx_busy_i && uart_en_i));
  p_rts_no_space_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_en_i && cfg.rts_en && !cfg.de_mode && !rx_space_i) |=> rts_de_o);
  p_de_tracks_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_en_i && cfg.de_mode) |=> (rts_de_o == (de_act ^ cfg.de_pol)));
endmodule

// File: tb/sim_uart_flow_gate.sv
module sim_uart_flow_gate;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic uart_en = 0, cts_en = 0, rts_en = 0, de_mode = 0, de_pol = 0;
  logic irq_en = 0, cts_n = 0, rx_space = 0, cts_clr = 0;
  logic tx_valid, tx_busy, tx_done;
  logic tx_start, pin, flag, irq;

  int req_cnt = 0, acc_cnt = 0, cnt = 0;
  int vectors = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_flow_gate u0 (
    .clk_i(clk), .rst_ni(rst_n), .uart_en_i(uart_en), .cts_en_i(cts_en),
    .rts_en_i(rts_en), .de_mode_i(de_mode), .de_pol_i(de_pol),
    .cts_irq_en_i(irq_en), .cts_n_i(cts_n), .tx_valid_i(tx_valid),
    .tx_busy_i(tx_busy), .tx_done_i(tx_done), .rx_space_i(rx_space),
    .cts_clr_i(cts_clr), .tx_start_o(tx_start), .rts_de_o(pin),
    .cts_flag_o(flag), .cts_irq_o(irq)
  );

  // shifter model: busy for FRAME cycles, done in the last one
  assign tx_valid = req_cnt > acc_cnt;
  assign tx_done  = tx_busy && cnt == 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; cnt <= 0; acc_cnt <= 0;
    end else if (tx_start) begin
      tx_busy <= 1'b1; cnt <= FRAME - 1; acc_cnt <= acc_cnt + 1;
    end else if (tx_busy) begin
      if (cnt == 0) tx_busy <= 1'b0;
      else          cnt <= cnt - 1;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_cfg(logic c, logic r, logic m, logic p);
    @(negedge clk);
    uart_en = 0; cts_en = c; rts_en = r; de_mode = m; de_pol = p;
    tick();
    uart_en = 1;
    tick();
  endtask

  task automatic drain();
    while (tx_valid || tx_busy) tick();
    tick();
  endtask

  task automatic clear_flag();
    @(negedge clk); cts_clr = 1; tick(); cts_clr = 0; tick();
  endtask

  task automatic t_reset();
    irq_en = 1;
    tick(); tick();
    rst_n = 1;
    tick();
    chk("R10 start", tx_start, 1'b0);
    chk("R10 pin", pin, 1'b0);
    chk("R10 flag", flag, 1'b0);
    chk("R10 irq", irq, 1'b0);
    irq_en = 0;
  endtask

  task automatic t_cts_hold_then_go();
    int bad = 0;
    set_cfg(1, 0, 0, 0);
    @(negedge clk); cts_n = 1;
    repeat (4) tick();
    req_cnt++;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (tx_start) bad++;
    end
    chk_int("R1 no start while nCTS high", bad, 0);
    @(negedge clk); cts_n = 0; #1;
    chk("R3 start at n0", tx_start, 1'b0);
    tick();
    chk("R3 start after 1 edge", tx_start, 1'b0);
    tick();
    chk("R3 start after 2 edges", tx_start, 1'b1);
    drain();
  endtask

  task automatic t_mid_frame();
    int acc0, bad = 0;
    acc0 = acc_cnt;
    @(negedge clk); req_cnt += 2; #1;
    chk("R2 first start", tx_start, 1'b1);
    tick();
    cts_n = 1;
    while (tx_busy) begin
      tick();
      if (tx_start) bad++;
    end
    repeat (5) begin
      tick();
      if (tx_start) bad++;
    end
    chk_int("R2 no second start while held", bad, 0);
    chk_int("R2 first frame ran, one accepted", acc_cnt, acc0 + 1);
    @(negedge clk); cts_n = 0;
    repeat (4) tick();
    chk_int("R2 second started after nCTS low", acc_cnt, acc0 + 2);
    drain();
  endtask

  task automatic t_rts();
    set_cfg(0, 1, 0, 0);
    @(negedge clk); rx_space = 1;
    tick(); tick();
    chk("R4 space -> nRTS low", pin, 1'b0);
    rx_space = 0;
    tick();
    chk("R4 no space -> nRTS high", pin, 1'b1);
    rx_space = 1; uart_en = 0;
    tick();
    chk("R4 disabled -> nRTS high", pin, 1'b1);
    uart_en = 1;
    tick();
    chk("R4 re-enabled -> nRTS low", pin, 1'b0);
  endtask

  task automatic t_de(logic pol, string req);
    int bad = 0;
    set_cfg(0, 0, 1, pol);
    tick();
    chk({req, " idle level"}, pin, pol);
    @(negedge clk); req_cnt++;
    for (int i = 0; i < FRAME + 4; i++) begin
      tick();
      if (pin !== (tx_busy ^ pol)) bad++;
    end
    chk_int({req, " pin follows frame"}, bad, 0);
    chk({req, " back to idle"}, pin, pol);
    drain();
  endtask

  task automatic t_lock();
    set_cfg(0, 1, 0, 0);
    @(negedge clk); rx_space = 0;
    tick();
    chk("R7 baseline nRTS high", pin, 1'b1);
    rts_en = 0;
    repeat (3) tick();
    chk("R7 rts_en change ignored while enabled", pin, 1'b1);
    uart_en = 0;
    tick(); tick();
    uart_en = 1;
    tick();
    chk("R7 change applied after disable", pin, 1'b0);
  endtask

  task automatic t_flag();
    set_cfg(1, 0, 0, 0);
    irq_en = 1;
    clear_flag();
    chk("R8 flag cleared", flag, 1'b0);
    @(negedge clk); cts_n = ~cts_n;
    tick();
    tick();
    chk("R8 flag not yet", flag, 1'b0);
    tick();
    chk("R8 flag set", flag, 1'b1);
    chk("R8 irq set", irq, 1'b1);
    irq_en = 0; #1;
    chk("R8 irq masked", irq, 1'b0);
    repeat (3) tick();
    chk("R8 flag sticky", flag, 1'b1);
    clear_flag();
    chk("R8 flag cleared by clr", flag, 1'b0);
    @(negedge clk); cts_n = 0;
    repeat (4) tick();
    clear_flag();
  endtask

  task automatic t_disabled();
    set_cfg(0, 0, 0, 0);
    clear_flag();
    @(negedge clk); cts_n = 1;
    repeat (4) tick();
    chk("R9 flag untouched", flag, 1'b0);
    @(negedge clk); req_cnt++; #1;
    chk("R9 start ignores nCTS", tx_start, 1'b1);
    chk("R9 pin idles low", pin, 1'b0);
    drain();
    @(negedge clk); cts_n = 0;
    repeat (4) tick();
    chk("R9 no flag on toggle", flag, 1'b0);
  endtask

  task automatic t_busy_gate();
    int bad = 0;
    set_cfg(0, 0, 0, 0);
    @(negedge clk); uart_en = 0; req_cnt++;
    for (int i = 0; i < 4; i++) begin
      tick();
      if (tx_start) bad++;
    end
    chk_int("R11 no start while disabled", bad, 0);
    uart_en = 1; req_cnt++; #1;
    chk("R11 start once enabled", tx_start, 1'b1);
    bad = 0;
    tick();
    while (tx_busy) begin
      if (tx_start) bad++;
      tick();
    end
    chk_int("R11 no start while busy", bad, 0);
    drain();
  endtask

  initial begin
    t_reset();
    t_cts_hold_then_go();
    t_mid_frame();
    t_rts();
    t_de(1'b0, "R5");
    t_de(1'b1, "R6");
    t_lock();
    t_flag();
    t_disabled();
    t_busy_gate();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule